// File: doc/BRIEF.md
# Serial Port Status Flag Unit

This block keeps the seven status flags of an asynchronous serial port and produces its interrupt request. The transmit and receive engines report events as single-cycle strobes: a byte loaded into the transmit shifter, received data ready, line idle, overrun, noise and framing error. The transmit engine also drives a level, `tx_busy`, that stays high while a data frame, preamble or break is going out. The engines themselves are outside this block.

A CPU-style register bus reads the status word and accesses the data register. Flags never clear on a single access. A status read first arms clearing for the flags it saw set. A later access to the data register then clears only those armed flags: a write for the transmit flags, a read for the receive flags. A new event for a flag cancels its pending clear. The interrupt output is a level built from the flags and four enable inputs.

Top module: `uart_stat_flags`

## Requirements
- R1: `bus_rdata` follows `bus_addr` combinationally. At address 0x10 it returns the status word: bit 7 transmit-empty, bit 6 transmit-complete, bit 5 receive-full, bit 4 line-idle, bit 3 overrun, bit 2 noise, bit 1 framing, bit 0 always 0. At any other address it returns 0. Only a `bus_rd` or `bus_wr` strobe has side effects.
- R2: During and right after reset, transmit-empty is 1 and every other flag is 0. With `tx_busy` high the status word is 0x80.
- R3: A `ev_tx_load` strobe sets transmit-empty at the next clock edge.
- R4: Transmit-empty and transmit-complete clear at the edge of a write to the data register (address 0x11). This happens only if an earlier status read saw the flag set. A data write with no such read leaves them set.
- R5: Transmit-complete sets at the clock edge after a cycle in which transmit-empty is 1 and `tx_busy` is low. It stays 0 while `tx_busy` is high.
- R6: The receive-full, line-idle, overrun, noise and framing strobes each set their flag at the next edge. Each flag clears at the edge of a data register read that follows a status read which saw it set.
- R7: An event that arrives after the arming status read keeps its flag set, both at the data access that follows and afterwards. A strobe in the same cycle as a clearing access also wins.
- R8: A status read arms only the flags that were set when the read happened. A flag set after the read survives the next data access.
- R9: A write to the status address changes no flag. A data read does not clear the transmit flags. A data write does not clear the receive flags.
- R10: `irq_out` is a combinational level. It is the OR of: `irq_en[0]` AND transmit-empty, `irq_en[1]` AND transmit-complete, `irq_en[2]` AND (receive-full OR overrun), and `irq_en[3]` AND line-idle. Noise and framing errors never raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Register address |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data (ignored by the flags) |
| bus_rdata | output | 8 | Read data, status word at 0x10 |
| ev_tx_load | input | 1 | Data register moved into the transmit shifter |
| tx_busy | input | 1 | Frame, preamble or break being shifted out |
| ev_rx_full | input | 1 | Received byte moved into the data register |
| ev_line_idle | input | 1 | Receive line found idle |
| ev_overrun | input | 1 | Receive overrun |
| ev_noise | input | 1 | Noise seen in a received frame |
| ev_frame_err | input | 1 | Framing error in a received frame |
| irq_en | input | 4 | Interrupt enables: tx-empty, tx-complete, receive, idle |
| irq_out | output | 1 | Interrupt request level |

## Verification
On every cycle, the assertions check the following:
- a transmit-load or receive strobe is always followed by its flag being set;
- a flag only falls after an armed, matching data access;
- arming only follows a status read that saw the flag;
- transmit-complete only rises when transmit-empty was set and the shifter was idle;
- the interrupt stays low when no enable is set.

The bench scenarios are what show the full ordering rules. They cover an event landing between the read and the access, flags set after the read surviving it, wrong-direction accesses leaving flags alone, and the exact status word and interrupt level for each combination of enables.

// File: rtl/uart_stat_pkg.sv
`timescale 1ns/1ps
package uart_stat_pkg;
  localparam int NFLAG  = 7;
  localparam int F_FE   = 0;
  localparam int F_NF   = 1;
  localparam int F_OR   = 2;
  localparam int F_IDLE = 3;
  localparam int F_RDRF = 4;
  localparam int F_TC   = 5;
  localparam int F_TDRE = 6;
  localparam int NEN    = 4;

  // status word: flags occupy bits 7..1, bit 0 unimplemented
  function automatic logic [7:0] pack_status(input logic [NFLAG-1:0] f);
    return {f, 1'b0};
  endfunction

  // transmit-side flags clear on data write, receive-side on data read
  function automatic logic is_tx_flag(input int idx);
    return (idx == F_TDRE) || (idx == F_TC);
  endfunction

  function automatic logic flag_reset_val(input int idx);
    return (idx == F_TDRE);
  endfunction

  function automatic logic irq_of(input logic [NFLAG-1:0] f,
                                  input logic [NEN-1:0] en);
    return (en[0] & f[F_TDRE]) |
           (en[1] & f[F_TC]) |
           (en[2] & (f[F_RDRF] | f[F_OR])) |
           (en[3] & f[F_IDLE]);
  endfunction
endpackage

// File: rtl/usf_bus_decode.sv
`timescale 1ns/1ps
module usf_bus_decode #(
  parameter int AW = 8,
  parameter logic [AW-1:0] STAT_ADDR = 8'h10,
  parameter logic [AW-1:0] DATA_ADDR = 8'h11
) (
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_rd,
  input  logic          bus_wr,
  input  logic [7:0]    status_word,
  output logic          stat_rd,
  output logic          data_rd,
  output logic          data_wr,
  output logic [7:0]    rdata
);
  logic hit_stat, hit_data;

  assign hit_stat = (bus_addr == STAT_ADDR);
  assign hit_data = (bus_addr == DATA_ADDR);

  // writes to the status address are deliberately not decoded
  assign stat_rd = bus_rd & hit_stat;
  assign data_rd = bus_rd & hit_data;
  assign data_wr = bus_wr & hit_data;

  always_comb begin
    rdata = 8'h00;
    if (hit_stat) rdata = status_word;
  end
endmodule

// File: rtl/usf_flag_cell.sv
`timescale 1ns/1ps
module usf_flag_cell #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,   // event for this flag
  input  logic peek_i,  // status register read
  input  logic take_i,  // matching data register access
  output logic flag_o,
  output logic armed_o
);
  logic flag_q, arm_q;
  logic flag_d, arm_d;

  always_comb begin
    flag_d = flag_q;
    if (set_i)               flag_d = 1'b1;
    else if (arm_q && take_i) flag_d = 1'b0;
  end

  always_comb begin
    arm_d = arm_q;
    if (set_i)                 arm_d = 1'b0;  // fresh event cancels clearing
    else if (take_i)           arm_d = 1'b0;
    else if (peek_i && flag_q) arm_d = 1'b1;  // only flags visible at read
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= RST_VAL;
      arm_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      arm_q  <= arm_d;
    end
  end

  assign flag_o  = flag_q;
  assign armed_o = arm_q;
endmodule

// File: rtl/usf_irq_merge.sv
`timescale 1ns/1ps
module usf_irq_merge
  import uart_stat_pkg::*;
(
  input  logic [NFLAG-1:0] flags,
  input  logic [NEN-1:0]   irq_en,
  output logic             irq
);
  assign irq = irq_of(flags, irq_en);
endmodule

// File: rtl/uart_stat_flags.sv
`timescale 1ns/1ps
module uart_stat_flags
  import uart_stat_pkg::*;
#(
  parameter int AW = 8,
  parameter logic [AW-1:0] STAT_ADDR = 8'h10,
  parameter logic [AW-1:0] DATA_ADDR = 8'h11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_rd,
  input  logic          bus_wr,
  input  logic [7:0]    bus_wdata,
  output logic [7:0]    bus_rdata,
  input  logic          ev_tx_load,
  input  logic          tx_busy,
  input  logic          ev_rx_full,
  input  logic          ev_line_idle,
  input  logic          ev_overrun,
  input  logic          ev_noise,
  input  logic          ev_frame_err,
  input  logic [NEN-1:0] irq_en,
  output logic          irq_out
);
  logic             stat_rd, data_rd, data_wr;
  logic [NFLAG-1:0] flags, arms, set_vec, take_vec;
  logic             tc_cond;
  logic [7:0]       status_word;
  logic             wdata_unused;

  assign wdata_unused = ^bus_wdata;  // data register storage lives elsewhere

  usf_bus_decode #(.AW(AW), .STAT_ADDR(STAT_ADDR), .DATA_ADDR(DATA_ADDR)) u_dec (
    .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .status_word(status_word), .stat_rd(stat_rd), .data_rd(data_rd),
    .data_wr(data_wr), .rdata(bus_rdata)
  );

  // transmit-complete: transmit-empty with the shifter quiet
  assign tc_cond = flags[F_TDRE] & ~tx_busy & ~flags[F_TC];

  always_comb begin
    set_vec         = '0;
    set_vec[F_TDRE] = ev_tx_load;
    set_vec[F_TC]   = tc_cond;
    set_vec[F_RDRF] = ev_rx_full;
    set_vec[F_IDLE] = ev_line_idle;
    set_vec[F_OR]   = ev_overrun;
    set_vec[F_NF]   = ev_noise;
    set_vec[F_FE]   = ev_frame_err;
  end

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    if (is_tx_flag(i)) begin : g_tx
      assign take_vec[i] = data_wr;
    end else begin : g_rx
      assign take_vec[i] = data_rd;
    end
    usf_flag_cell #(.RST_VAL(flag_reset_val(i))) u_cell (
      .clk(clk), .rst_n(rst_n), .set_i(set_vec[i]), .peek_i(stat_rd),
      .take_i(take_vec[i]), .flag_o(flags[i]), .armed_o(arms[i])
    );
  end

  assign status_word = pack_status(flags);

  usf_irq_merge u_irq (.flags(flags), .irq_en(irq_en), .irq(irq_out));
endmodule

// File: rtl/uart_stat_flags_chk.sv
`timescale 1ns/1ps
module uart_stat_flags_chk
  import uart_stat_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             stat_rd,
  input logic             data_rd,
  input logic             data_wr,
  input logic [NFLAG-1:0] flags,
  input logic [NFLAG-1:0] arms,
  input logic             ev_tx_load,
  input logic             ev_rx_full,
  input logic             tx_busy,
  input logic [NEN-1:0]   irq_en,
  input logic             irq_out,
  input logic [7:0]       bus_rdata
);
  assert_rdata_tdre_R1: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd |-> (bus_rdata[7] == flags[F_TDRE]) && !bus_rdata[0]);

  assert_tdre_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_tx_load |=> flags[F_TDRE]);

  assert_tdre_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flags[F_TDRE]) |-> $past(arms[F_TDRE]) && $past(data_wr));

  assert_tc_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[F_TC]) |-> $past(flags[F_TDRE]) && !$past(tx_busy));

  assert_rx_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flags[F_RDRF]) |-> $past(arms[F_RDRF]) && $past(data_rd));

  assert_event_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rx_full |=> flags[F_RDRF] && !arms[F_RDRF]);

  assert_arm_visible_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(arms[F_RDRF]) |-> $past(stat_rd) && $past(flags[F_RDRF]));

  assert_irq_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en == '0) |-> !irq_out);

  assert_irq_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (|flags[F_TDRE:F_OR]));
endmodule

bind uart_stat_flags uart_stat_flags_chk u_chk (
  .clk(clk), .rst_n(rst_n), .stat_rd(stat_rd), .data_rd(data_rd),
  .data_wr(data_wr), .flags(flags), .arms(arms), .ev_tx_load(ev_tx_load),
  .ev_rx_full(ev_rx_full), .tx_busy(tx_busy), .irq_en(irq_en),
  .irq_out(irq_out), .bus_rdata(bus_rdata)
);

// File: tb/sim_uart_stat_flags.sv
`timescale 1ns/1ps
module sim_uart_stat_flags;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] bus_addr = 8'h10;
  logic       bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       ev_tx_load = 0, tx_busy = 1, ev_rx_full = 0, ev_line_idle = 0;
  logic       ev_overrun = 0, ev_noise = 0, ev_frame_err = 0;
  logic [3:0] irq_en = 4'h0;
  logic       irq_out;
  int checks = 0, failures = 0;
  bit done = 0;

  always #4 clk = ~clk;  // 125 MHz

  uart_stat_flags u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ev_tx_load(ev_tx_load), .tx_busy(tx_busy), .ev_rx_full(ev_rx_full),
    .ev_line_idle(ev_line_idle), .ev_overrun(ev_overrun), .ev_noise(ev_noise),
    .ev_frame_err(ev_frame_err), .irq_en(irq_en), .irq_out(irq_out)
  );

  // vector: {req[3:0], rd, wr, addr[7:0], ev[6:0], expected status[7:0]}
  // ev bits: 6 tx_load, 4 rx_full, 3 line_idle, 2 overrun, 1 noise, 0 frame
  localparam int NV = 24;
  localparam logic [28:0] VECS [NV] = '{
    {4'd8, 1'b1, 1'b0, 8'h10, 7'h00, 8'h80},  // R8 arm tx-empty
    {4'd4, 1'b0, 1'b1, 8'h11, 7'h00, 8'h00},  // R4 armed write clears
    {4'd4, 1'b0, 1'b1, 8'h11, 7'h00, 8'h00},  // R4 write without arm
    {4'd3, 1'b0, 1'b0, 8'h10, 7'h40, 8'h80},  // R3 load sets tx-empty
    {4'd6, 1'b0, 1'b0, 8'h10, 7'h10, 8'hA0},  // R6 rx-full
    {4'd6, 1'b0, 1'b0, 8'h10, 7'h06, 8'hAC},  // R6 overrun + noise
    {4'd8, 1'b1, 1'b0, 8'h10, 7'h00, 8'hAC},  // R8 arm visible flags
    {4'd6, 1'b0, 1'b0, 8'h10, 7'h01, 8'hAE},  // R6 framing after read
    {4'd8, 1'b1, 1'b0, 8'h11, 7'h00, 8'h82},  // R8 framing survives
    {4'd9, 1'b0, 1'b1, 8'h10, 7'h00, 8'h82},  // R9 status write ignored
    {4'd1, 1'b1, 1'b0, 8'h10, 7'h00, 8'h82},  // R1 status read
    {4'd6, 1'b0, 1'b0, 8'h10, 7'h10, 8'hA2},  // R6 rx-full again
    {4'd9, 1'b1, 1'b0, 8'h11, 7'h00, 8'hA0},  // R9 read keeps tx-empty
    {4'd7, 1'b1, 1'b0, 8'h10, 7'h00, 8'hA0},  // R7 arm rx-full
    {4'd7, 1'b0, 1'b0, 8'h10, 7'h10, 8'hA0},  // R7 event cancels arm
    {4'd7, 1'b1, 1'b0, 8'h11, 7'h00, 8'hA0},  // R7 rx-full kept
    {4'd6, 1'b0, 1'b0, 8'h10, 7'h08, 8'hB0},  // R6 line idle
    {4'd6, 1'b1, 1'b0, 8'h10, 7'h00, 8'hB0},  // R6 arm
    {4'd6, 1'b1, 1'b0, 8'h11, 7'h00, 8'h80},  // R6 read clears rx side
    {4'd4, 1'b0, 1'b1, 8'h11, 7'h00, 8'h00},  // R4 old arm still valid
    {4'd6, 1'b0, 1'b0, 8'h10, 7'h10, 8'h20},  // R6 rx-full
    {4'd6, 1'b1, 1'b0, 8'h10, 7'h00, 8'h20},  // R6 arm
    {4'd9, 1'b0, 1'b1, 8'h11, 7'h00, 8'h20},  // R9 write keeps rx-full
    {4'd6, 1'b1, 1'b0, 8'h11, 7'h00, 8'h00}   // R6 read clears
  };

  task automatic check(input bit ok, input string req,
                       input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic apply(input logic rd, input logic wr, input logic [7:0] addr,
                       input logic [6:0] ev);
    @(negedge clk);
    bus_rd = rd; bus_wr = wr; bus_addr = addr; bus_wdata = 8'h5A;
    ev_tx_load = ev[6]; ev_rx_full = ev[4]; ev_line_idle = ev[3];
    ev_overrun = ev[2]; ev_noise = ev[1]; ev_frame_err = ev[0];
    @(posedge clk);
    #1;
    bus_rd = 0; bus_wr = 0; bus_addr = 8'h10;
    ev_tx_load = 0; ev_rx_full = 0; ev_line_idle = 0;
    ev_overrun = 0; ev_noise = 0; ev_frame_err = 0;
    #1;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    checks++; failures++;
    $display("FAIL watchdog actual=00 expected=01");
    finish_run();
  end

  initial begin
    #20;
    check(bus_rdata == 8'h80, "R2 in reset", bus_rdata, 8'h80);
    @(negedge clk); rst_n = 1;
    #1 check(bus_rdata == 8'h80, "R2 after reset", bus_rdata, 8'h80);
    check(irq_out == 1'b0, "R10 no enables", {7'd0, irq_out}, 8'h00);
    bus_addr = 8'h11;
    #1 check(bus_rdata == 8'h00, "R1 other address", bus_rdata, 8'h00);
    bus_addr = 8'h10;

    for (int k = 0; k < NV; k++) begin
      logic [28:0] v;
      v = VECS[k];
      apply(v[24], v[23], v[22:15], v[14:8]);
      if (bus_rdata != v[7:0])
        $display("FAIL detail: table step %0d, req R%0d", k, v[28:25]);
      check(bus_rdata == v[7:0], "table", bus_rdata, v[7:0]);
    end

    // R5 transmit-complete held while busy, sets when idle
    apply(0, 0, 8'h10, 7'h40);
    apply(0, 0, 8'h10, 7'h00);
    check(bus_rdata == 8'h80, "R5 held while busy", bus_rdata, 8'h80);
    @(negedge clk); tx_busy = 0;
    @(posedge clk); #2;
    check(bus_rdata == 8'hC0, "R5 sets when idle", bus_rdata, 8'hC0);
    irq_en = 4'b0010; #1;
    check(irq_out == 1'b1, "R10 tc enable", {7'd0, irq_out}, 8'h01);
    irq_en = 4'b0000; #1;
    check(irq_out == 1'b0, "R10 tc disabled", {7'd0, irq_out}, 8'h00);
    apply(1, 0, 8'h10, 7'h00);
    apply(0, 1, 8'h11, 7'h00);
    check(bus_rdata == 8'h00, "R4 both tx flags clear", bus_rdata, 8'h00);
    @(negedge clk); tx_busy = 1;

    // R10 interrupt combinations
    apply(0, 0, 8'h10, 7'h02);
    irq_en = 4'hF; #1;
    check(irq_out == 1'b0, "R10 noise no irq", {7'd0, irq_out}, 8'h00);
    apply(0, 0, 8'h10, 7'h04);
    irq_en = 4'b0100; #1;
    check(irq_out == 1'b1, "R10 overrun irq", {7'd0, irq_out}, 8'h01);
    irq_en = 4'b1011; #1;
    check(irq_out == 1'b0, "R10 overrun masked", {7'd0, irq_out}, 8'h00);
    apply(0, 0, 8'h10, 7'h08);
    irq_en = 4'b1000; #1;
    check(irq_out == 1'b1, "R10 idle irq", {7'd0, irq_out}, 8'h01);
    irq_en = 4'b0001; #1;
    check(irq_out == 1'b0, "R10 tx-empty clear", {7'd0, irq_out}, 8'h00);
    apply(0, 0, 8'h10, 7'h40);
    check(irq_out == 1'b1, "R10 tx-empty irq", {7'd0, irq_out}, 8'h01);
    check(bus_rdata == 8'h9C, "R3 status after load", bus_rdata, 8'h9C);

    finish_run();
  end
endmodule